// File: doc/BRIEF.md
# Image Fitness Accumulator and Best Tracker

This block scores candidate image-filter configurations during an evolutionary search. For each candidate, the filtered pixel stream and the matching reference pixel stream arrive together, one pair per cycle, qualified by a valid strobe. The block adds the absolute difference of every valid pair into a running score. A smaller score is better, and a score of zero means the filter reproduces the reference exactly.

A candidate begins with a start pulse that carries its chromosome index. It ends with an end-of-frame pulse. One cycle after end-of-frame, the block presents the finished score. In the same cycle it updates the best score and the best index seen in the current generation. A generation-start pulse returns the best score to all-ones. A sticky flag reports that some candidate in the generation scored zero. The selection logic downstream uses the best index to choose which chromosomes seed the next generation.

The accumulator width comes from the image dimensions and the pixel width. A full frame of worst-case differences therefore never wraps.

Top module: `fit_score_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, the outputs are: `score` 0, `score_valid` 0, `best_score` all-ones, `best_idx` 0 and `perfect` 0.
- R2: Each cycle with `pix_valid` high adds |`pix_filt` − `pix_ref`| (unsigned pixels) to the running score. Cycles with `pix_valid` low add nothing, whatever the pixel inputs carry.
- R3: `cand_start` discards the previous running sum and latches `cand_idx`. A pixel that is valid in the same cycle is the first term of the new sum.
- R4: The pixel in the `frame_end` cycle is counted. `score` shows the finished sum and `score_valid` is high on the cycle after `frame_end`, and only then.
- R5: A finished score strictly below `best_score` replaces it and loads `best_idx` with that candidate's index. Both appear in the same cycle as `score_valid`.
- R6: A finished score equal to or above `best_score` leaves `best_score` and `best_idx` unchanged, so a tie keeps the earlier index.
- R7: A finished score of zero sets `perfect`. The flag stays set until `gen_start`.
- R8: `gen_start` sets `best_score` to all-ones, `best_idx` to 0 and `perfect` to 0 on the next cycle. It takes precedence over a finish in the same cycle.
- R9: A full frame of IMG_COLS×IMG_ROWS pixels, each differing by the maximum 2^PIX_W−1, yields exactly that product with no wrap.
- R10: `score` holds its value on every cycle that does not follow a `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_start | input | 1 | Start of a generation; clears the best tracking |
| cand_start | input | 1 | First cycle of a candidate |
| cand_idx | input | IDX_W | Chromosome index, sampled with `cand_start` |
| pix_valid | input | 1 | Pixel pair valid |
| pix_filt | input | PIX_W | Filtered pixel |
| pix_ref | input | PIX_W | Reference pixel |
| frame_end | input | 1 | Last cycle of the candidate's frame |
| score | output | ACC_W | Finished score of the last candidate |
| score_valid | output | 1 | One-cycle strobe for a new `score` |
| best_score | output | ACC_W | Lowest finished score in this generation |
| best_idx | output | IDX_W | Index of the candidate holding `best_score` |
| perfect | output | 1 | A zero score was seen in this generation |

## Verification
The bench aims at the boundaries of a frame. A pixel that shares a cycle with `cand_start` would be lost by a design that clears after adding. A pixel that shares a cycle with `frame_end` would be missing from a score taken from the registered sum. Two candidates that both score zero expose a `<=` comparison, which would move the best index to the later one. A frame of all-maximum differences, together with a `gen_start` that coincides with a finish, exposes a narrow accumulator that wraps and a clear that loses to the update.

// File: rtl/fit_pkg.sv
// Shared helpers for the fitness scoring block.
// Assumes unsigned pixels of equal width on both streams.
package fit_pkg;

    // Absolute difference of two unsigned pixels.
    function automatic logic [15:0] abs_diff16(input logic [15:0] a, input logic [15:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/fit_sad_accum.sv
// Sum-of-absolute-differences accumulator for one candidate at a time.
// It exposes the finished sum combinationally in the frame_end cycle,
// so that the best tracker can update on the same edge as the score register.
// Assumes: PIX_W <= 16, PIX_W <= ACC_W, and at most one frame of pixels per candidate.
module fit_sad_accum #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 24,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_start,
    input  logic [IDX_W-1:0] cand_idx,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_filt,
    input  logic [PIX_W-1:0] pix_ref,
    input  logic             frame_end,
    output logic [ACC_W-1:0] fin_sum,
    output logic [IDX_W-1:0] fin_idx,
    output logic [ACC_W-1:0] score_q,
    output logic             score_valid_q
);
    import fit_pkg::*;

    logic [ACC_W-1:0] acc_q;
    logic [IDX_W-1:0] idx_q;
    logic [ACC_W-1:0] term;
    logic [15:0]      d16;

    // Widen the pixel difference and gate it with valid.
    always_comb begin
        d16  = abs_diff16(16'(pix_filt), 16'(pix_ref));
        term = '0;
        if (pix_valid) term[PIX_W-1:0] = d16[PIX_W-1:0];
    end

    // Next running sum and owner index, including this cycle's pixel.
    always_comb begin
        fin_sum = cand_start ? term : (acc_q + term);
        fin_idx = cand_start ? cand_idx : idx_q;
    end

    // Hold the running sum and index; capture the score at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q         <= '0;
            idx_q         <= '0;
            score_q       <= '0;
            score_valid_q <= 1'b0;
        end else begin
            acc_q         <= fin_sum;
            idx_q         <= fin_idx;
            score_valid_q <= frame_end;
            if (frame_end) score_q <= fin_sum;
        end
    end

    // R9: without a new candidate, the sum never decreases (no wrap).
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cand_start)) |-> (acc_q >= $past(acc_q)));

    // R10: the score register moves only after a frame end.
    a_r10_score_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(frame_end)) |-> $stable(score_q));

    // R4: the strobe follows frame_end by exactly one cycle.
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid_q == $past(frame_end && rst_n));
endmodule

// File: rtl/fit_best_track.sv
// Keeps the lowest finished score of a generation and its owner's index.
// Ties keep the incumbent. A zero score sets a flag that stays set until generation start.
// Assumes a finish is announced by fin_valid in the frame_end cycle.
module fit_best_track #(
    parameter int ACC_W = 24,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_start,
    input  logic             fin_valid,
    input  logic [ACC_W-1:0] fin_sum,
    input  logic [IDX_W-1:0] fin_idx,
    output logic [ACC_W-1:0] best_q,
    output logic [IDX_W-1:0] best_idx_q,
    output logic             perfect_q
);
    logic better;

    // Strict comparison: only an improvement replaces the incumbent.
    always_comb better = fin_valid && (fin_sum < best_q);

    // Clear on generation start, else take improvements and note exact matches.
    always_ff @(posedge clk) begin
        if (!rst_n || gen_start) begin
            best_q     <= '1;
            best_idx_q <= '0;
            perfect_q  <= 1'b0;
        end else begin
            if (better) begin
                best_q     <= fin_sum;
                best_idx_q <= fin_idx;
            end
            if (fin_valid && fin_sum == '0) perfect_q <= 1'b1;
        end
    end

    // R5: an improvement is taken on the next edge.
    a_r5_take_better: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_valid && !gen_start && fin_sum < best_q) |=> (best_q == $past(fin_sum)));

    // R6: a tie or a worse score leaves the index alone.
    a_r6_tie_keeps_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_valid && !gen_start && fin_sum >= best_q) |=> $stable(best_idx_q));

    // R7: the perfect flag is sticky within a generation.
    a_r7_perfect_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(perfect_q) && !$past(gen_start)) |-> perfect_q);

    // R8: generation start restores the all-ones best.
    a_r8_gen_clear: assert property (@(posedge clk) disable iff (!rst_n)
        gen_start |=> (best_q == '1 && !perfect_q));
endmodule

// File: rtl/fit_score_tracker.sv
// Top: scores one candidate filter per frame by sum of absolute differences
// against reference pixels, and tracks the best candidate of the generation.
// Assumes at most IMG_COLS*IMG_ROWS valid pixels between cand_start and frame_end.
module fit_score_tracker #(
    parameter int PIX_W    = 8,
    parameter int IMG_COLS = 256,
    parameter int IMG_ROWS = 256,
    parameter int IDX_W    = 8,
    localparam int MAX_SCORE = ((1 << PIX_W) - 1) * IMG_COLS * IMG_ROWS,
    localparam int ACC_W     = $clog2(MAX_SCORE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_start,
    input  logic             cand_start,
    input  logic [IDX_W-1:0] cand_idx,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_filt,
    input  logic [PIX_W-1:0] pix_ref,
    input  logic             frame_end,
    output logic [ACC_W-1:0] score,
    output logic             score_valid,
    output logic [ACC_W-1:0] best_score,
    output logic [IDX_W-1:0] best_idx,
    output logic             perfect
);
    logic [ACC_W-1:0] fin_sum;
    logic [IDX_W-1:0] fin_idx;

    // Per-candidate accumulation and score register.
    fit_sad_accum #(.PIX_W(PIX_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .cand_start(cand_start), .cand_idx(cand_idx),
        .pix_valid(pix_valid), .pix_filt(pix_filt), .pix_ref(pix_ref),
        .frame_end(frame_end), .fin_sum(fin_sum), .fin_idx(fin_idx),
        .score_q(score), .score_valid_q(score_valid)
    );

    // Generation-wide best tracking.
    fit_best_track #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_best (
        .clk(clk), .rst_n(rst_n), .gen_start(gen_start), .fin_valid(frame_end),
        .fin_sum(fin_sum), .fin_idx(fin_idx), .best_q(best_score),
        .best_idx_q(best_idx), .perfect_q(perfect)
    );

    // R1: a strobe never appears in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !score_valid);
endmodule

// File: tb/tb_fit_score_tracker.sv
// Bench: a behavioural reference model, updated at every rising edge and compared at
// every falling edge, plus directed checks on frame boundaries.
module tb_fit_score_tracker;
    localparam int PIX_W = 8;
    localparam int COLS  = 4;
    localparam int ROWS  = 3;
    localparam int IDX_W = 4;
    localparam int NPIX  = COLS * ROWS;
    localparam int MAXS  = 255 * NPIX;
    localparam int AW    = $clog2(MAXS + 1);
    localparam int ONES  = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_start = 1'b0, cand_start = 1'b0, pix_valid = 1'b0, frame_end = 1'b0;
    logic [IDX_W-1:0] cand_idx = '0;
    logic [PIX_W-1:0] pix_filt = '0, pix_ref = '0;
    logic [AW-1:0] score, best_score;
    logic score_valid, perfect;
    logic [IDX_W-1:0] best_idx;

    int errors = 0, checks = 0;
    int m_acc = 0, m_idx = 0, m_score = 0, m_sv = 0, m_best = ONES, m_bidx = 0, m_perf = 0;
    bit run_done = 1'b0;

    always #10 clk = ~clk;

    fit_score_tracker #(.PIX_W(PIX_W), .IMG_COLS(COLS), .IMG_ROWS(ROWS), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .gen_start(gen_start), .cand_start(cand_start),
        .cand_idx(cand_idx), .pix_valid(pix_valid), .pix_filt(pix_filt), .pix_ref(pix_ref),
        .frame_end(frame_end), .score(score), .score_valid(score_valid),
        .best_score(best_score), .best_idx(best_idx), .perfect(perfect)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        int d, nacc, nidx;
        if (!rst_n) begin
            m_acc = 0; m_idx = 0; m_score = 0; m_sv = 0; m_best = ONES; m_bidx = 0; m_perf = 0;
        end else begin
            d = pix_valid ? ((pix_filt > pix_ref) ? pix_filt - pix_ref : pix_ref - pix_filt) : 0;
            nacc = cand_start ? d : m_acc + d;
            nidx = cand_start ? int'(cand_idx) : m_idx;
            m_sv = frame_end;
            if (frame_end) m_score = nacc;
            if (gen_start) begin
                m_best = ONES; m_bidx = 0; m_perf = 0;
            end else if (frame_end) begin
                if (nacc < m_best) begin m_best = nacc; m_bidx = nidx; end
                if (nacc == 0) m_perf = 1;
            end
            m_acc = nacc; m_idx = nidx;
        end
    end

    // Compare on every cycle.
    always @(negedge clk) if (!run_done) begin
        check("R2/R4 score", int'(score), m_score);
        check("R4 score_valid", int'(score_valid), m_sv);
        check("R5 best_score", int'(best_score), m_best);
        check("R6 best_idx", int'(best_idx), m_bidx);
        check("R7 perfect", int'(perfect), m_perf);
    end

    // Drives one frame. mode 0: mixed, 1: max difference, 2: identical pixels.
    // Every third pixel is preceded by an idle cycle that carries junk data.
    task automatic run_frame(input int idx, input int mode, input bit gen_at_end);
        for (int i = 0; i < NPIX; i++) begin
            if (i % 3 == 1) begin
                @(negedge clk);
                cand_start = 0; frame_end = 0; pix_valid = 0;
                pix_filt = 8'hFF; pix_ref = 8'h00;
            end
            @(negedge clk);
            pix_valid  = 1;
            cand_start = (i == 0);
            cand_idx   = IDX_W'(idx);
            frame_end  = (i == NPIX - 1);
            gen_start  = gen_at_end && (i == NPIX - 1);
            case (mode)
                1:       begin pix_filt = 8'd255; pix_ref = 8'd0; end
                2:       begin pix_filt = PIX_W'(i * 21); pix_ref = PIX_W'(i * 21); end
                default: begin pix_filt = PIX_W'(i * 23 + idx); pix_ref = PIX_W'(200 - i * 7); end
            endcase
        end
        @(negedge clk);
        pix_valid = 0; cand_start = 0; frame_end = 0; gen_start = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 score reset", int'(score), 0);
        check("R1 best reset", int'(best_score), ONES);
        check("R1 perfect reset", int'(perfect), 0);
        rst_n = 1;
        @(negedge clk); gen_start = 1;
        @(negedge clk); gen_start = 0;
        run_frame(3, 0, 0);
        check("R4 strobe after frame", int'(score_valid), 1);
        check("R5 first candidate is best", int'(best_idx), 3);
        run_frame(5, 1, 0);
        check("R9 full max frame", int'(score), MAXS);
        @(negedge clk);
        check("R10 score held", int'(score), MAXS);
        check("R4 single strobe", int'(score_valid), 0);
        run_frame(7, 2, 0);
        check("R7 perfect set", int'(perfect), 1);
        check("R3 zero best idx", int'(best_idx), 7);
        run_frame(9, 2, 0);
        check("R6 tie keeps earlier idx", int'(best_idx), 7);
        run_frame(2, 0, 0);
        check("R7 perfect stays", int'(perfect), 1);
        run_frame(11, 2, 1);
        check("R8 gen_start wins over finish", int'(best_score), ONES);
        check("R8 perfect cleared", int'(perfect), 0);
        check("R3 score of candidate with first pixel at start", int'(score), 0);
        run_frame(4, 0, 0);
        check("R5 new generation best idx", int'(best_idx), 4);
        repeat (3) @(negedge clk);
        run_done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule